// File: doc/BRIEF.md
# Byte-Lane Banked Memory Decoder

This block sits between a 16-bit processor memory bus and two 8-bit memory banks. One bank carries the low byte of every word and is reached when byte address bit zero is low. The other carries the high byte and is reached when the active-low high-byte enable is low. From these two lane selects, the read and write strobes and the memory/IO select, the block produces a chip enable, an output enable and a write enable for each bank. It also raises a region flag whenever a memory access falls in read-only space.

The word-address space is split in half. The upper half is read-only memory. Its contents are computed from a seed parameter, and it is always read as a full word, whatever the byte selects say. The processor keeps the byte it wants and drops the other. The lower half is read/write memory, held in two internal byte arrays, and each lane there is gated on its own. The read data is registered once on the clock edge of the access and is zero whenever no memory read takes place.

Top module: `byte_lane_mem_dec`

## Requirements
- R1: The low lane (data bits 7..0) is served by the even bank and the high lane (data bits 15..8) by the odd bank. A byte written to one lane never appears on the other lane.
- R2: In the read/write region (word address top bit 0), during a memory access, the even bank chip enable is low exactly when address bit zero is low, and the odd bank chip enable is low exactly when the high-byte enable is low.
- R3: In the read-only region (word address top bit 1), a memory read drives both chip enables low regardless of address bit zero and the high-byte enable. The returned word is ROM_SEED XOR {i, ~i}, where i is the 8-bit zero-extended bank index.
- R4: In the read-only region, each bank's output enable equals the read strobe OR the inverted memory/IO select, and both write enables stay high.
- R5: In the read/write region, a memory read drives the output enable low and the write enable high on each enabled lane. A memory write (write strobe low, read strobe high) drives the write enable low and the output enable high on each enabled lane. The output enable and write enable of a lane are never both low.
- R6: A write to the read-only region enables no bank and does not change what a later read there returns.
- R7: When no memory read or write is active (both strobes high, or memory/IO select low), all chip enables are high, the region flag is low, and the read data goes to zero.
- R8: Read data is registered: the value for an access appears after the clock edge that ends it. Read/write-region lanes that are not selected read as zero.
- R9: A word access at an odd byte address (bit zero high, high-byte enable low) touches only the high lane, in a single cycle. The even byte at that index is left unchanged.
- R10: The bank index is the word address without its top bit. The region flag is high only during a memory access to the read-only region.
- R11: When both strobes are low together, the cycle is a read and no write enable is asserted.
- R12: After reset the read data is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wa_i | input | WA_W | Word address (processor address bit 1 upward) |
| a0_i | input | 1 | Byte address bit zero, low selects the even lane |
| bhe_n_i | input | 1 | High-byte enable, active low |
| rd_n_i | input | 1 | Read strobe, active low |
| wr_n_i | input | 1 | Write strobe, active low |
| mio_i | input | 1 | High for memory, low for IO |
| wdata_i | input | 16 | Write data |
| even_ce_n_o | output | 1 | Even bank chip enable, active low |
| even_oe_n_o | output | 1 | Even bank output enable, active low |
| even_we_n_o | output | 1 | Even bank write enable, active low |
| odd_ce_n_o | output | 1 | Odd bank chip enable, active low |
| odd_oe_n_o | output | 1 | Odd bank output enable, active low |
| odd_we_n_o | output | 1 | Odd bank write enable, active low |
| rom_sel_o | output | 1 | High during a memory access to the read-only region |
| rdata_o | output | 16 | Registered read data |

## Verification
The read/write array is first filled with full-word writes. After that, random mixes of region, lane selects, strobe combinations and memory/IO select are applied, so that the low-byte, high-byte, full-word and no-lane cases each show whether the lane gating follows the two selects independently. Reads of the read-only region with every byte-select combination tell the always-both-lanes rule apart from the gated one. Directed cycles cover an odd-address word, a write into read-only space, IO-space strobes and both strobes low, each followed by a read that exposes any unintended change to storage.

// File: rtl/blmd_pkg.sv
package blmd_pkg;

  localparam int LANE_W  = 8;
  localparam int N_LANES = 2;
  localparam int BUS_W   = LANE_W * N_LANES;

  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_t;

  typedef struct packed {
    logic ce_n;
    logic oe_n;
    logic we_n;
  } lane_ctl_t;

  // Read-only content: seed mixed with the index and its complement.
  function automatic logic [BUS_W-1:0] rom_word(input logic [15:0] idx,
                                                input logic [15:0] seed);
    logic [7:0] i8;
    i8 = idx[7:0];
    return seed ^ {i8, ~i8};
  endfunction

endpackage

// File: rtl/blmd_decode.sv
module blmd_decode
  import blmd_pkg::*;
#(
  parameter int WA_W = 8
) (
  input  logic [WA_W-1:0]               wa_i,
  input  logic                          a0_i,
  input  logic                          bhe_n_i,
  input  logic                          rd_n_i,
  input  logic                          wr_n_i,
  input  logic                          mio_i,
  output acc_t                          acc_o,
  output logic                          rom_o,
  output lane_ctl_t [N_LANES-1:0]       ctl_o
);

  logic               mem_rd;
  logic               mem_wr;
  logic [N_LANES-1:0] lane_req;

  always_comb begin
    mem_rd = mio_i & ~rd_n_i;
    // read takes precedence when both strobes are low
    mem_wr = mio_i & ~wr_n_i & rd_n_i;
    if (mem_rd)      acc_o = ACC_READ;
    else if (mem_wr) acc_o = ACC_WRITE;
    else             acc_o = ACC_IDLE;
    rom_o       = wa_i[WA_W-1];
    lane_req[0] = ~a0_i;
    lane_req[1] = ~bhe_n_i;
  end

  for (genvar l = 0; l < N_LANES; l++) begin : g_lane
    logic sel;
    always_comb begin
      if (rom_o) sel = (acc_o == ACC_READ);
      else       sel = (acc_o != ACC_IDLE) & lane_req[l];
      ctl_o[l].ce_n = ~sel;
      ctl_o[l].oe_n = rd_n_i | ~mio_i | ~sel;
      ctl_o[l].we_n = ~(sel & (acc_o == ACC_WRITE) & ~rom_o);
    end
  end

endmodule

// File: rtl/blmd_ram_lane.sv
module blmd_ram_lane #(
  parameter int AW     = 7,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [LANE_W-1:0] wdata_i,
  output logic [LANE_W-1:0] rdata_o
);

  localparam int DEPTH = 1 << AW;

  logic [LANE_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en_i) begin
      mem_q[addr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[addr_i];

endmodule

// File: rtl/blmd_rom_lane.sv
module blmd_rom_lane
  import blmd_pkg::*;
#(
  parameter int          AW   = 7,
  parameter int          LANE = 0,
  parameter logic [15:0] SEED = 16'hA55A
) (
  input  logic [AW-1:0]     addr_i,
  output logic [LANE_W-1:0] rdata_o
);

  logic [BUS_W-1:0] word;

  always_comb begin
    word    = rom_word(16'(addr_i), SEED);
    rdata_o = word[LANE*LANE_W +: LANE_W];
  end

endmodule

// File: rtl/byte_lane_mem_dec.sv
module byte_lane_mem_dec
  import blmd_pkg::*;
#(
  parameter int          WA_W     = 8,
  parameter logic [15:0] ROM_SEED = 16'hA55A
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [WA_W-1:0] wa_i,
  input  logic            a0_i,
  input  logic            bhe_n_i,
  input  logic            rd_n_i,
  input  logic            wr_n_i,
  input  logic            mio_i,
  input  logic [15:0]     wdata_i,
  output logic            even_ce_n_o,
  output logic            even_oe_n_o,
  output logic            even_we_n_o,
  output logic            odd_ce_n_o,
  output logic            odd_oe_n_o,
  output logic            odd_we_n_o,
  output logic            rom_sel_o,
  output logic [15:0]     rdata_o
);

  localparam int BANK_AW = WA_W - 1;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  acc_t                    acc;
  logic                    rom;
  lane_ctl_t [N_LANES-1:0] ctl;
  logic [BANK_AW-1:0]      bank_idx;
  logic [BUS_W-1:0]        rd_next;
  logic [BUS_W-1:0]        rdata_q;

  assign bank_idx = wa_i[BANK_AW-1:0];

  blmd_decode #(.WA_W(WA_W)) u_dec (
    .wa_i    (wa_i),
    .a0_i    (a0_i),
    .bhe_n_i (bhe_n_i),
    .rd_n_i  (rd_n_i),
    .wr_n_i  (wr_n_i),
    .mio_i   (mio_i),
    .acc_o   (acc),
    .rom_o   (rom),
    .ctl_o   (ctl)
  );

  for (genvar l = 0; l < N_LANES; l++) begin : g_lane
    logic [LANE_W-1:0] ram_b;
    logic [LANE_W-1:0] rom_b;
    logic              wr_en;

    assign wr_en = ~ctl[l].we_n;

    blmd_ram_lane #(.AW(BANK_AW), .LANE_W(LANE_W)) u_ram (
      .clk     (clk),
      .wr_en_i (wr_en),
      .addr_i  (bank_idx),
      .wdata_i (wdata_i[l*LANE_W +: LANE_W]),
      .rdata_o (ram_b)
    );

    blmd_rom_lane #(.AW(BANK_AW), .LANE(l), .SEED(ROM_SEED)) u_rom (
      .addr_i  (bank_idx),
      .rdata_o (rom_b)
    );

    always_comb begin
      if (!ctl[l].ce_n && acc == ACC_READ)
        rd_next[l*LANE_W +: LANE_W] = rom ? rom_b : ram_b;
      else
        rd_next[l*LANE_W +: LANE_W] = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) rdata_q <= '0;
    else             rdata_q <= rd_next;
  end

  assign rdata_o     = rdata_q;
  assign even_ce_n_o = ctl[0].ce_n;
  assign even_oe_n_o = ctl[0].oe_n;
  assign even_we_n_o = ctl[0].we_n;
  assign odd_ce_n_o  = ctl[1].ce_n;
  assign odd_oe_n_o  = ctl[1].oe_n;
  assign odd_we_n_o  = ctl[1].we_n;
  assign rom_sel_o   = rom & (acc != ACC_IDLE);

endmodule

// File: rtl/blmd_checker.sv
module blmd_checker #(
  parameter int WA_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [WA_W-1:0] wa_i,
  input logic            a0_i,
  input logic            bhe_n_i,
  input logic            rd_n_i,
  input logic            wr_n_i,
  input logic            mio_i,
  input logic            even_ce_n_o,
  input logic            even_oe_n_o,
  input logic            even_we_n_o,
  input logic            odd_ce_n_o,
  input logic            odd_oe_n_o,
  input logic            odd_we_n_o,
  input logic            rom_sel_o,
  input logic [15:0]     rdata_o
);

  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(mio_i && (!rd_n_i || !wr_n_i)) |-> (even_ce_n_o && odd_ce_n_o && !rom_sel_o));

  assert_rom_both_lanes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mio_i && !rd_n_i && wa_i[WA_W-1]) |-> (!even_ce_n_o && !odd_ce_n_o));

  assert_rom_oe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wa_i[WA_W-1] |-> (even_oe_n_o == (rd_n_i || !mio_i)) &&
                     (odd_oe_n_o == (rd_n_i || !mio_i)) && even_we_n_o && odd_we_n_o);

  assert_rom_write_dead_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mio_i && rd_n_i && !wr_n_i && wa_i[WA_W-1]) |-> (even_ce_n_o && odd_ce_n_o));

  assert_ram_lane_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mio_i && (!rd_n_i || !wr_n_i) && !wa_i[WA_W-1]) |->
      ((even_ce_n_o == a0_i) && (odd_ce_n_o == bhe_n_i)));

  assert_no_oe_we_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!even_oe_n_o && !even_we_n_o) && !(!odd_oe_n_o && !odd_we_n_o));

  assert_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(mio_i && !rd_n_i) |=> (rdata_o == 16'h0000));

  assert_both_strobes_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mio_i && !rd_n_i && !wr_n_i) |-> (even_we_n_o && odd_we_n_o));

endmodule

bind byte_lane_mem_dec blmd_checker #(.WA_W(WA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wa_i        (wa_i),
  .a0_i        (a0_i),
  .bhe_n_i     (bhe_n_i),
  .rd_n_i      (rd_n_i),
  .wr_n_i      (wr_n_i),
  .mio_i       (mio_i),
  .even_ce_n_o (even_ce_n_o),
  .even_oe_n_o (even_oe_n_o),
  .even_we_n_o (even_we_n_o),
  .odd_ce_n_o  (odd_ce_n_o),
  .odd_oe_n_o  (odd_oe_n_o),
  .odd_we_n_o  (odd_we_n_o),
  .rom_sel_o   (rom_sel_o),
  .rdata_o     (rdata_o)
);

// File: tb/sim_byte_lane_mem_dec.sv
module sim_byte_lane_mem_dec;

  localparam int          WA_W     = 8;
  localparam int          DEPTH    = 1 << (WA_W - 1);
  localparam logic [15:0] ROM_SEED = 16'hA55A;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [WA_W-1:0] wa = '0;
  logic            a0 = 1'b0, bhe_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, mio = 1'b0;
  logic [15:0]     wd = '0;
  logic            e_ce, e_oe, e_we, o_ce, o_oe, o_we, rsel;
  logic [15:0]     rdata;

  int n_checks = 0;
  int n_fail   = 0;
  logic done   = 1'b0;

  logic [7:0] lo_m [DEPTH];
  logic [7:0] hi_m [DEPTH];

  always #4 clk = ~clk;

  byte_lane_mem_dec #(.WA_W(WA_W), .ROM_SEED(ROM_SEED)) u0 (
    .clk(clk), .rst_n(rst_n), .wa_i(wa), .a0_i(a0), .bhe_n_i(bhe_n),
    .rd_n_i(rd_n), .wr_n_i(wr_n), .mio_i(mio), .wdata_i(wd),
    .even_ce_n_o(e_ce), .even_oe_n_o(e_oe), .even_we_n_o(e_we),
    .odd_ce_n_o(o_ce), .odd_oe_n_o(o_oe), .odd_we_n_o(o_we),
    .rom_sel_o(rsel), .rdata_o(rdata)
  );

  task automatic check(input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // expected {rom_sel, e_ce, e_oe, e_we, o_ce, o_oe, o_we}
  function automatic logic [6:0] exp_ctl(input logic [WA_W-1:0] a, input logic b0,
      input logic bh_n, input logic r_n, input logic w_n, input logic m);
    logic rd, wr, rom, es, os;
    rd  = m && !r_n;
    wr  = m && !w_n && r_n;
    rom = a[WA_W-1];
    es  = rom ? rd : ((rd || wr) && !b0);
    os  = rom ? rd : ((rd || wr) && !bh_n);
    return {rom && (rd || wr),
            !es, !(es && rd), !(es && wr && !rom),
            !os, !(os && rd), !(os && wr && !rom)};
  endfunction

  function automatic logic [15:0] exp_rd(input logic [WA_W-1:0] a, input logic b0,
      input logic bh_n, input logic r_n, input logic m);
    logic [7:0] i8;
    int idx;
    idx = int'(a[WA_W-2:0]);
    i8  = 8'(idx);
    if (!(m && !r_n)) return 16'h0;
    if (a[WA_W-1]) return ROM_SEED ^ {i8, ~i8};
    return {bh_n ? 8'h00 : hi_m[idx], b0 ? 8'h00 : lo_m[idx]};
  endfunction

  // call at a falling edge; returns at the next falling edge
  task automatic cyc(input logic [WA_W-1:0] a, input logic b0, input logic bh_n,
                     input logic r_n, input logic w_n, input logic m,
                     input logic [15:0] d, input string tag_in);
    string tag;
    logic [15:0] er;
    int idx;
    tag = tag_in;
    if (tag == "") begin
      if (!(m && (!r_n || !w_n))) tag = "R7";
      else if (a[WA_W-1])         tag = "R3";
      else                        tag = "R5";
    end
    wa = a; a0 = b0; bhe_n = bh_n; rd_n = r_n; wr_n = w_n; mio = m; wd = d;
    #1;
    check(tag, "controls",
          16'({rsel, e_ce, e_oe, e_we, o_ce, o_oe, o_we}),
          16'(exp_ctl(a, b0, bh_n, r_n, w_n, m)));
    er = exp_rd(a, b0, bh_n, r_n, m);
    @(negedge clk);
    check(tag == "R7" ? "R7" : "R8", "rdata", rdata, er);
    idx = int'(a[WA_W-2:0]);
    if (m && !w_n && r_n && !a[WA_W-1]) begin
      if (!b0)   lo_m[idx] = d[7:0];
      if (!bh_n) hi_m[idx] = d[15:8];
    end
    wa = '0; rd_n = 1'b1; wr_n = 1'b1; mio = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R12", "rdata in reset", rdata, 16'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R12", "rdata after reset", rdata, 16'h0);

    // fill read/write space with full words (R1, R10)
    for (int i = 0; i < DEPTH; i++)
      cyc(WA_W'(i), 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 16'($urandom), "R10");
    for (int i = 0; i < 8; i++)
      cyc(WA_W'(i), 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 16'h0, "R1");

    // R1: low-byte write shows up only on the low lane
    cyc(WA_W'(5), 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 16'hBEEF, "R1");
    cyc(WA_W'(5), 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 16'h0, "R1");
    // R2: lane gating on the read/write side
    cyc(WA_W'(6), 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 16'h0, "R2");
    cyc(WA_W'(6), 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 16'h0, "R2");
    cyc(WA_W'(6), 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 16'h0, "R2");
    // R3, R4: read-only reads with every byte-select combination
    for (int s = 0; s < 4; s++)
      cyc(WA_W'(8'h80 + s * 9), s[0], s[1], 1'b0, 1'b1, 1'b1, 16'h0, "R3");
    cyc(WA_W'(8'hFF), 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 16'h0, "R4");
    cyc(WA_W'(8'h81), 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0, "R4");
    // R6: write to read-only space, then read it back
    cyc(WA_W'(8'h90), 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 16'h1234, "R6");
    cyc(WA_W'(8'h90), 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 16'h0, "R6");
    // R9: odd-address word touches the high lane only
    cyc(WA_W'(9), 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 16'hC3A5, "R9");
    cyc(WA_W'(9), 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 16'h0, "R9");
    // R7: IO space strobes and idle
    cyc(WA_W'(10), 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'hFFFF, "R7");
    cyc(WA_W'(10), 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0, "R7");
    cyc(WA_W'(10), 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 16'h0, "R7");
    // R11: both strobes low is a read, no write
    cyc(WA_W'(11), 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 16'h5555, "R11");
    cyc(WA_W'(11), 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 16'h0, "R11");

    // constrained random mix
    for (int n = 0; n < 1500; n++) begin
      int op;
      logic r_n, w_n;
      op = int'($urandom % 8);
      r_n = !(op <= 2 || op == 7);
      w_n = !((op >= 3 && op <= 5) || op == 7);
      cyc(WA_W'($urandom), 1'($urandom), 1'($urandom), r_n, w_n,
          ($urandom % 6) != 0, 16'($urandom), "");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule